// File: doc/BRIEF.md
# Base-Index Address Generator

This block forms the effective address for a memory-reference instruction. It takes a 3-bit base selector, a 3-bit index selector, a signed displacement and a 4-bit access class taken from the opcode. It reads the register values it needs from a flat bank of eight address registers and from three integer data registers. It then adds base, index and sign-extended displacement, with wraparound at the address width. The sum and two flags appear one clock after a request.

The index selector reaches into two register files. Codes 1 to 3 pick integer data registers, and codes 4 to 7 pick address registers 0 to 3. Address register 0 may therefore serve as an index but never as a base. A base selector of zero raises an illegal-operand flag. The access class gives the data size, and the alignment flag is judged from the low address bits against that size. The 48-bit floating type needs only 16-bit alignment.

There is no state machine. The only state is one result register stage with a valid bit. It is "idle" when no request arrived in the previous cycle and "loaded" when one did. The transition into "loaded" is a cycle with `req_valid` high, and the transition back to "idle" is a cycle with it low.

Top module: `bix_agen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request, `out_valid`, `eff_addr`, `misaligned` and `bad_base` are all zero.
- R2: One clock after a cycle with `req_valid` high, `eff_addr` equals base term + index term + the displacement sign-extended from DISP_W bits, taken modulo 2^ADDR_W.
- R3: An index selector of 000 makes the index term zero.
- R4: Index selectors 001, 010 and 011 use the values on `int_r1`, `int_r2` and `int_r3` as the index term.
- R5: Index selectors 100, 101, 110 and 111 use address registers 0, 1, 2 and 3 as the index term. Address register k sits at `addr_bank[k*ADDR_W +: ADDR_W]`.
- R6: A base selector of 000 sets `bad_base` in the result and makes the base term zero. Base selectors 1 to 7 use address register 1 to 7 and clear `bad_base`.
- R7: `acc_class` (opcode bits 4..1) sets the access size as follows. Classes 0 and 1 are 1 byte, 2 and 3 are 2 bytes, 4 and 5 are 4 bytes, 6 is 8 bytes, 9 is 4 bytes, 10 is 8 bytes and 11 is 16 bytes. `misaligned` is set when the effective address is not a multiple of that size.
- R8: Class 8 (48-bit floating) is aligned on any even address: `misaligned` equals bit 0 of the effective address.
- R9: Classes 7 and 12 to 15 carry no data access, and `misaligned` stays 0 for them at every address.
- R10: `out_valid` equals `req_valid` of the previous cycle. After a cycle with `req_valid` low, `eff_addr`, `misaligned` and `bad_base` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_sel | input | 3 | Base register selector |
| index_sel | input | 3 | Index register selector |
| disp | input | DISP_W | Signed displacement |
| acc_class | input | 4 | Opcode bits 4..1 giving the access size |
| addr_bank | input | 8*ADDR_W | Address registers 0..7, register k at bits k*ADDR_W upward |
| int_r1 | input | ADDR_W | Integer data register 1 |
| int_r2 | input | ADDR_W | Integer data register 2 |
| int_r3 | input | ADDR_W | Integer data register 3 |
| out_valid | output | 1 | Result valid |
| eff_addr | output | ADDR_W | Effective address |
| misaligned | output | 1 | Address is misaligned for the access size |
| bad_base | output | 1 | Base selector was zero |

## Verification
The bench uses the default ADDR_W of 64 and DISP_W of 16. A 16-bit displacement can be negative enough to pull a small base below zero, and an all-ones base plus a small positive offset reaches the 64-bit wraparound directly. The alignment sweep covers all sixteen access classes and the low four address bits, so every size up to 16 bytes is tested at each offset.

// File: rtl/bix_pkg.sv
package bix_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_AR  = 8;
    localparam int CLASS_W = 4;

    typedef enum logic [2:0] {
        SZ_NONE,
        SZ_B8,
        SZ_H16,
        SZ_W32,
        SZ_L64,
        SZ_M48,
        SZ_Q128
    } acc_size_e;

    // Mask of low address bits that must be zero for the given size
    function automatic logic [3:0] align_mask(acc_size_e sz);
        logic [3:0] m;
        unique case (sz)
            SZ_NONE: m = 4'b0000;
            SZ_B8:   m = 4'b0000;
            SZ_H16:  m = 4'b0001;
            SZ_M48:  m = 4'b0001;
            SZ_W32:  m = 4'b0011;
            SZ_L64:  m = 4'b0111;
            SZ_Q128: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/bix_size_decode.sv
module bix_size_decode
    import bix_pkg::*;
(
    input  logic [CLASS_W-1:0] acc_class,
    output acc_size_e          acc_size
);
    always_comb begin
        unique case (acc_class[3:1])
            3'b000:  acc_size = SZ_B8;
            3'b001:  acc_size = SZ_H16;
            3'b010:  acc_size = SZ_W32;
            3'b011:  acc_size = acc_class[0] ? SZ_NONE : SZ_L64;
            3'b100:  acc_size = acc_class[0] ? SZ_W32  : SZ_M48;
            3'b101:  acc_size = acc_class[0] ? SZ_Q128 : SZ_L64;
            default: acc_size = SZ_NONE;
        endcase
    end
endmodule

// File: rtl/bix_operand_sel.sv
module bix_operand_sel
    import bix_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [SEL_W-1:0]         base_sel,
    input  logic [SEL_W-1:0]         index_sel,
    input  logic [NUM_AR*ADDR_W-1:0] addr_bank,
    input  logic [ADDR_W-1:0]        int_r1,
    input  logic [ADDR_W-1:0]        int_r2,
    input  logic [ADDR_W-1:0]        int_r3,
    output logic [ADDR_W-1:0]        base_val,
    output logic [ADDR_W-1:0]        index_val,
    output logic                     base_bad
);
    logic [ADDR_W-1:0] ar [NUM_AR];

    generate
        for (genvar k = 0; k < NUM_AR; k++) begin : g_split
            assign ar[k] = addr_bank[k*ADDR_W +: ADDR_W];
        end
    endgenerate

    always_comb begin
        base_bad = (base_sel == '0);
        base_val = base_bad ? '0 : ar[base_sel];
    end

    always_comb begin
        unique case (index_sel)
            3'd0:    index_val = '0;
            3'd1:    index_val = int_r1;
            3'd2:    index_val = int_r2;
            3'd3:    index_val = int_r3;
            default: index_val = ar[{1'b0, index_sel[1:0]}];
        endcase
    end

    // R3
    always_comb begin
        if (index_sel == 3'd0) begin
            no_index_chk: assert (index_val == '0);
        end
    end
endmodule

// File: rtl/bix_align_chk.sv
module bix_align_chk
    import bix_pkg::*;
(
    input  logic [3:0] addr_lo,
    input  acc_size_e  acc_size,
    output logic       misaligned
);
    always_comb begin
        misaligned = |(addr_lo & align_mask(acc_size));
    end
endmodule

// File: rtl/bix_agen.sv
module bix_agen
    import bix_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               base_sel,
    input  logic [2:0]               index_sel,
    input  logic [DISP_W-1:0]        disp,
    input  logic [3:0]               acc_class,
    input  logic [8*ADDR_W-1:0]      addr_bank,
    input  logic [ADDR_W-1:0]        int_r1,
    input  logic [ADDR_W-1:0]        int_r2,
    input  logic [ADDR_W-1:0]        int_r3,
    output logic                     out_valid,
    output logic [ADDR_W-1:0]        eff_addr,
    output logic                     misaligned,
    output logic                     bad_base
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] index_val;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum_next;
    logic              base_bad_next;
    logic              mis_next;
    acc_size_e         acc_size;

    bix_operand_sel #(.ADDR_W(ADDR_W)) u_sel (
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .addr_bank (addr_bank),
        .int_r1    (int_r1),
        .int_r2    (int_r2),
        .int_r3    (int_r3),
        .base_val  (base_val),
        .index_val (index_val),
        .base_bad  (base_bad_next)
    );

    bix_size_decode u_dec (
        .acc_class (acc_class),
        .acc_size  (acc_size)
    );

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum_next = base_val + index_val + disp_ext;
    end

    bix_align_chk u_align (
        .addr_lo    (sum_next[3:0]),
        .acc_size   (acc_size),
        .misaligned (mis_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            eff_addr   <= '0;
            misaligned <= 1'b0;
            bad_base   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                eff_addr   <= sum_next;
                misaligned <= mis_next;
                bad_base   <= base_bad_next;
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(eff_addr) && $stable(misaligned)));

    // R6
    bad_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_sel == 3'd0) |=> bad_base);

    // R9
    no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (acc_class == 4'd7 || acc_class[3:2] == 2'b11)) |=> !misaligned);

    // R2
    plain_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_sel == 3'd1 && index_sel == 3'd0 && disp == '0)
        |=> eff_addr == $past(addr_bank[ADDR_W +: ADDR_W]));
endmodule

// File: tb/bix_agen_test.sv
`timescale 1ns/1ps
module bix_agen_test;
    localparam int AW = 64;
    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [2:0]     base_sel = '0;
    logic [2:0]     index_sel = '0;
    logic [DW-1:0]  disp = '0;
    logic [3:0]     acc_class = '0;
    logic [AW-1:0]  ar [8];
    logic [8*AW-1:0] addr_bank;
    logic [AW-1:0]  int_r1 = '0, int_r2 = '0, int_r3 = '0;
    logic           out_valid, misaligned, bad_base;
    logic [AW-1:0]  eff_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) addr_bank[k*AW +: AW] = ar[k];
    end

    bix_agen #(.ADDR_W(AW), .DISP_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_sel(base_sel), .index_sel(index_sel), .disp(disp),
        .acc_class(acc_class), .addr_bank(addr_bank),
        .int_r1(int_r1), .int_r2(int_r2), .int_r3(int_r3),
        .out_valid(out_valid), .eff_addr(eff_addr),
        .misaligned(misaligned), .bad_base(bad_base)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_index(input logic [2:0] s);
        if (s == 0) return '0;
        if (s == 1) return int_r1;
        if (s == 2) return int_r2;
        if (s == 3) return int_r3;
        return ar[s - 4];
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [2:0] b, input logic [2:0] x, input logic [DW-1:0] d);
        logic [AW-1:0] bv;
        bv = (b == 0) ? '0 : ar[b];
        return bv + exp_index(x) + AW'($signed(d));
    endfunction

    function automatic logic exp_mis(input logic [3:0] c, input logic [AW-1:0] a);
        int g;
        case (c)
            0, 1: g = 1;
            2, 3: g = 2;
            4, 5: g = 4;
            6: g = 8;
            8: g = 2;
            9: g = 4;
            10: g = 8;
            11: g = 16;
            default: g = 0;
        endcase
        if (g == 0) return 1'b0;
        return (a % g) != 0;
    endfunction

    // Drive one request, then sample one cycle later away from the edge
    task automatic issue(input logic [2:0] b, input logic [2:0] x, input logic [DW-1:0] d, input logic [3:0] c);
        @(negedge clk);
        req_valid = 1'b1; base_sel = b; index_sel = x; disp = d; acc_class = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid", AW'(out_valid), '0);
        check("R1 eff_addr", eff_addr, '0);
        check("R1 misaligned", AW'(misaligned), '0);
        check("R1 bad_base", AW'(bad_base), '0);
    endtask

    task automatic t_base_disp;
        for (int b = 1; b < 8; b++) begin
            issue(3'(b), 3'd0, 16'h0040, 4'd0);
            check("R2/R3 base+disp", eff_addr, exp_addr(3'(b), 3'd0, 16'h0040));
            check("R2 out_valid", AW'(out_valid), 1);
            check("R6 bad_base clear", AW'(bad_base), 0);
        end
        issue(3'd2, 3'd0, 16'hFFF0, 4'd0);
        check("R2 negative disp", eff_addr, ar[2] - 64'd16);
    endtask

    task automatic t_int_index;
        for (int x = 1; x < 4; x++) begin
            issue(3'd3, 3'(x), 16'h0008, 4'd0);
            check("R4 int index", eff_addr, exp_addr(3'd3, 3'(x), 16'h0008));
        end
    endtask

    task automatic t_addr_index;
        for (int x = 4; x < 8; x++) begin
            issue(3'd5, 3'(x), 16'h0000, 4'd0);
            check("R5 addr index", eff_addr, ar[5] + ar[x-4]);
        end
    endtask

    task automatic t_bad_base;
        issue(3'd0, 3'd1, 16'h0004, 4'd0);
        check("R6 bad_base set", AW'(bad_base), 1);
        check("R6 base term zero", eff_addr, int_r1 + 64'd4);
    endtask

    task automatic t_wrap;
        logic [AW-1:0] keep;
        keep = ar[7];
        ar[7] = '1;
        issue(3'd7, 3'd0, 16'h0003, 4'd0);
        check("R2 wraparound", eff_addr, 64'd2);
        ar[7] = keep;
    endtask

    task automatic t_align;
        logic [AW-1:0] keep;
        keep = ar[1];
        for (int c = 0; c < 16; c++) begin
            for (int off = 0; off < 16; off++) begin
                ar[1] = 64'h0000_1000_0000_0000 + 64'(off);
                issue(3'd1, 3'd0, 16'h0000, 4'(c));
                if (c == 8)
                    check("R8 medium align", AW'(misaligned), AW'(off % 2));
                else if (c == 7 || c >= 12)
                    check("R9 no access", AW'(misaligned), 0);
                else
                    check("R7 size align", AW'(misaligned), AW'(exp_mis(4'(c), ar[1])));
            end
        end
        ar[1] = keep;
    endtask

    task automatic t_idle;
        logic [AW-1:0] last_a;
        logic last_m, last_b;
        issue(3'd4, 3'd2, 16'h0001, 4'd2);
        last_a = eff_addr; last_m = misaligned; last_b = bad_base;
        @(negedge clk);
        base_sel = 3'd0; index_sel = 3'd7; disp = 16'h1234; acc_class = 4'd11;
        @(negedge clk);
        check("R10 valid low", AW'(out_valid), 0);
        check("R10 addr hold", eff_addr, last_a);
        check("R10 mis hold", AW'(misaligned), AW'(last_m));
        check("R10 bad hold", AW'(bad_base), AW'(last_b));
    endtask

    initial begin
        for (int k = 0; k < 8; k++) ar[k] = 64'h0100_0000_0000_0000 * (k + 1) + 64'(k * 64'h111);
        int_r1 = 64'h0000_0000_0000_2000;
        int_r2 = 64'hFFFF_FFFF_FFFF_F000;
        int_r3 = 64'h0000_0123_4567_8000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_disp();
        t_int_index();
        t_addr_index();
        t_bad_base();
        t_wrap();
        t_align();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule